// File: doc/BRIEF.md
# Serial-Channel EEPROM Responder

This block models a small non-volatile store that sits on one channel of a serial command-list bus. The interpreter sends it a framed byte stream: a transmit count, a receive count, an opcode byte, then the rest of the transmitted bytes. The block decodes the frame and returns a short reply stream. It understands three operations. A status query reports the array size and a busy flag. A block read returns eight bytes. A block write stores eight bytes and acknowledges with one byte.

The array is either 4 Kbit (64 blocks of 8 bytes) or 16 Kbit (256 blocks), chosen by a parameter. Blocks are addressed by a single index byte, so the byte address is the index times 8. Indices past the end wrap around. After each accepted write the part stays busy for a parameterised number of cycles. Reads and writes that arrive during that window are refused. Frames tagged with any channel other than the device's own are consumed and produce nothing.

Both byte streams use valid/ready. An input byte moves on a cycle where `in_valid` and `in_ready` are both high. The block drops `in_ready` from the moment a frame is complete until the last reply byte has been taken, so the sender must hold its byte until `in_ready` returns. A reply byte moves on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low the block holds `out_valid`, `out_data`, `out_last` and `out_err` unchanged.

Top module: `sc_eeprom`

## Requirements
- R1: A frame begins with a byte carrying `in_start`, which holds the transmit count. The receive count follows, then the opcode, then (transmit count minus 1) payload bytes. A start byte always restarts framing, even in the middle of a frame, and a byte without `in_start` that arrives while no frame is open is dropped.
- R2: Only frames whose `in_chan`, sampled with the start byte, equals `DEV_CHAN` are answered. Frames on other channels are consumed without any reply byte and without touching the array.
- R3: A status frame (transmit 1, receive 3, opcode 0x00) returns 3 bytes. The first two are the type code, high byte first: 0x80,0x00 for the 4 Kbit array (`BIG_ARRAY`=0) and 0x40,0x00 for the 16 Kbit array. The third is a flag byte whose bit 7 is set while the device is busy, with every other bit 0.
- R4: A read frame (transmit 2, receive 8, opcode 0x04, then an index byte) returns the 8 bytes of that block, lowest byte address first.
- R5: A write frame (transmit 10, receive 1, opcode 0x05, an index byte, then 8 data bytes) stores the data bytes in order from the lowest byte address and returns a single 0x00 byte.
- R6: The block index is taken modulo the number of blocks (64 or 256).
- R7: After an accepted write the device reports busy for `BUSY_CYCLES` clock cycles and then reports idle.
- R8: While busy, a read returns one error beat and a write returns the single byte 0x80 and leaves the array unchanged.
- R9: A frame whose counts do not match its opcode, or whose opcode is unknown, returns exactly one beat with `out_err`=1, data 0x00 and `out_last`=1.
- R10: Reply bytes are held stable while `out_ready` is low. `out_last` marks only the final byte of a reply. `in_ready` is low while a reply is waiting or being sent.
- R11: After reset, `out_valid` is low, `in_ready` is high and the device is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_start | input | 1 | Marks the first byte of a frame |
| in_chan | input | CHAN_W | Channel tag, sampled with the start byte |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Receiver can take a reply byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| out_err | output | 1 | Beat reports a refused or malformed frame |

## Verification
On every cycle, the assertions check the handshake rules: reply beats stay stable under back-pressure, no input is taken while a reply is in flight, and error beats are single terminal zero bytes. They also check two links between the write path and the busy timer: a write always raises busy, and no write reaches the array while busy. Stored contents, index wrap, channel filtering, resynchronisation on a start byte and the exact busy window are only visible end to end. The bench covers these by writing and reading back every block of the 4 Kbit array and by sending frames with wrong channels, wrong counts and truncations.

// File: rtl/sce_pkg.sv
package sce_pkg;

  localparam logic [7:0] OP_STATUS = 8'h00;
  localparam logic [7:0] OP_READ   = 8'h04;
  localparam logic [7:0] OP_WRITE  = 8'h05;
  localparam logic [7:0] FLAG_IDLE = 8'h00;
  localparam logic [7:0] FLAG_BUSY = 8'h80;

  typedef struct packed {
    logic        chan_ok;
    logic [7:0]  tx_cnt;
    logic [7:0]  rx_cnt;
    logic [7:0]  op;
    logic [7:0]  blk;
    logic [63:0] payload;
  } frame_t;

  typedef enum logic [2:0] {
    RK_SILENT,
    RK_STATUS,
    RK_READ,
    RK_WRITE,
    RK_FAULT
  } reply_kind_e;

  function automatic reply_kind_e classify(frame_t f);
    if (!f.chan_ok)
      return RK_SILENT;
    if (f.op == OP_STATUS && f.tx_cnt == 8'd1 && f.rx_cnt == 8'd3)
      return RK_STATUS;
    if (f.op == OP_READ && f.tx_cnt == 8'd2 && f.rx_cnt == 8'd8)
      return RK_READ;
    if (f.op == OP_WRITE && f.tx_cnt == 8'd10 && f.rx_cnt == 8'd1)
      return RK_WRITE;
    return RK_FAULT;
  endfunction

endpackage

// File: rtl/sce_frame_rx.sv
module sce_frame_rx
  import sce_pkg::*;
#(
  parameter int CHAN_W   = 3,
  parameter int DEV_CHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_start,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              hold,
  output logic              job_valid,
  output frame_t            job,
  input  logic              job_take
);

  typedef enum logic [2:0] {P_TX, P_RX, P_OP, P_PAY, P_DONE} pstate_e;

  pstate_e    st;
  frame_t     fr;
  logic [7:0] left;
  logic [7:0] idx;
  logic       fire;

  assign in_ready  = (st != P_DONE) && !hold;
  assign fire      = in_valid && in_ready;
  assign job_valid = (st == P_DONE);
  assign job       = fr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= P_TX;
      fr   <= '0;
      left <= '0;
      idx  <= '0;
    end else if (st == P_DONE) begin
      if (job_take) st <= P_TX;
    end else if (fire) begin
      if (in_start) begin
        fr.chan_ok <= (in_chan == CHAN_W'(DEV_CHAN));
        fr.tx_cnt  <= in_data;
        fr.rx_cnt  <= '0;
        fr.op      <= '0;
        fr.blk     <= '0;
        fr.payload <= '0;
        st         <= P_RX;
      end else begin
        case (st)
          P_RX: begin
            fr.rx_cnt <= in_data;
            st        <= P_OP;
          end
          P_OP: begin
            fr.op <= in_data;
            idx   <= '0;
            if (fr.tx_cnt <= 8'd1) begin
              st <= P_DONE;
            end else begin
              left <= fr.tx_cnt - 8'd1;
              st   <= P_PAY;
            end
          end
          P_PAY: begin
            if (idx == 8'd0)
              fr.blk <= in_data;
            else if (idx <= 8'd8)
              fr.payload <= {fr.payload[55:0], in_data};
            if (idx != 8'hFF) idx <= idx + 8'd1;
            left <= left - 8'd1;
            if (left == 8'd1) st <= P_DONE;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/sce_busy_timer.sv
module sce_busy_timer #(
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  generate
    if (BUSY_CYCLES == 0) begin : g_none
      assign busy = 1'b0;
    end else begin : g_count
      localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt <= '0;
        else if (start)
          cnt <= CNT_W'(BUSY_CYCLES);
        else if (cnt != '0)
          cnt <= cnt - 1'b1;
      end

      assign busy = (cnt != '0);
    end
  endgenerate

endmodule

// File: rtl/sce_store.sv
module sce_store #(
  parameter int BLOCKS = 64,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [63:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data
);

  logic [63:0] mem [BLOCKS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/sce_reply_tx.sv
module sce_reply_tx
  import sce_pkg::*;
#(
  parameter int          IDX_W     = 6,
  parameter logic [15:0] TYPE_CODE = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_valid,
  input  frame_t           job,
  output logic             job_take,
  input  logic             busy,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [63:0]      rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [63:0]      wr_data,
  output logic             active,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             out_err
);

  reply_kind_e kind;
  logic [63:0] sbuf;
  logic [3:0]  left;
  logic        err_q;

  assign kind     = classify(job);
  assign active   = (left != 4'd0);
  assign job_take = job_valid && !active;
  assign rd_idx   = job.blk[IDX_W-1:0];
  assign wr_idx   = job.blk[IDX_W-1:0];
  assign wr_data  = job.payload;
  assign wr_en    = job_take && (kind == RK_WRITE) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbuf  <= '0;
      left  <= '0;
      err_q <= 1'b0;
    end else if (job_take) begin
      case (kind)
        RK_STATUS: begin
          sbuf  <= {TYPE_CODE, (busy ? FLAG_BUSY : FLAG_IDLE), 40'h0};
          left  <= 4'd3;
          err_q <= 1'b0;
        end
        RK_READ: begin
          if (busy) begin
            sbuf  <= '0;
            left  <= 4'd1;
            err_q <= 1'b1;
          end else begin
            sbuf  <= rd_data;
            left  <= 4'd8;
            err_q <= 1'b0;
          end
        end
        RK_WRITE: begin
          sbuf  <= {(busy ? FLAG_BUSY : FLAG_IDLE), 56'h0};
          left  <= 4'd1;
          err_q <= 1'b0;
        end
        RK_FAULT: begin
          sbuf  <= '0;
          left  <= 4'd1;
          err_q <= 1'b1;
        end
        default: ;
      endcase
    end else if (out_valid && out_ready) begin
      sbuf <= {sbuf[55:0], 8'h00};
      left <= left - 4'd1;
    end
  end

  assign out_valid = active;
  assign out_data  = sbuf[63:56];
  assign out_last  = (left == 4'd1);
  assign out_err   = err_q;

endmodule

// File: rtl/sc_eeprom.sv
module sc_eeprom
  import sce_pkg::*;
#(
  parameter bit BIG_ARRAY   = 1'b0,
  parameter int CHAN_W      = 3,
  parameter int DEV_CHAN    = 4,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_start,
  input  logic [CHAN_W-1:0] in_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              out_err
);

  localparam int          BLOCKS    = BIG_ARRAY ? 256 : 64;
  localparam int          IDX_W     = $clog2(BLOCKS);
  localparam logic [15:0] TYPE_CODE = BIG_ARRAY ? 16'h4000 : 16'h8000;

  frame_t           job;
  logic             job_valid;
  logic             job_take;
  logic             tx_active;
  logic             busy;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [63:0]      wr_data;
  logic [63:0]      rd_data;

  sce_frame_rx #(
    .CHAN_W   (CHAN_W),
    .DEV_CHAN (DEV_CHAN)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_start  (in_start),
    .in_chan   (in_chan),
    .hold      (tx_active),
    .job_valid (job_valid),
    .job       (job),
    .job_take  (job_take)
  );

  sce_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wr_en),
    .busy  (busy)
  );

  sce_store #(
    .BLOCKS (BLOCKS),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  sce_reply_tx #(
    .IDX_W     (IDX_W),
    .TYPE_CODE (TYPE_CODE)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .job_valid (job_valid),
    .job       (job),
    .job_take  (job_take),
    .busy      (busy),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .active    (tx_active),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_err   (out_err)
  );

endmodule

// File: rtl/sce_checks.sv
module sce_checks #(
  parameter int BUSY_CYCLES = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_err,
  input logic       wr_en,
  input logic       busy
);

  // R10: reply beat frozen under back-pressure
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_err)));

  // R10: no intake while a reply is in flight
  a_r10_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9: error beat is a lone zero byte
  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_last && out_data == 8'h00));

  // R7: an accepted write raises busy
  a_r7_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (busy || (BUSY_CYCLES == 0)));

  // R8: array untouched while busy
  a_r8_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);

  // R11: reset clears the reply stream
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind sc_eeprom sce_checks #(.BUSY_CYCLES(BUSY_CYCLES)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .out_err   (out_err),
  .wr_en     (wr_en),
  .busy      (busy)
);

// File: tb/test_sc_eeprom.sv
`timescale 1ns/1ps
module test_sc_eeprom;

  localparam int BUSYC = 40;
  localparam int NBLK  = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_start = 1'b0;
  logic [2:0] in_chan = 3'd0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_err;

  always #4 clk = ~clk;

  sc_eeprom #(
    .BIG_ARRAY   (1'b0),
    .CHAN_W      (3),
    .DEV_CHAN    (4),
    .BUSY_CYCLES (BUSYC)
  ) i_sc_eeprom (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_start  (in_start),
    .in_chan   (in_chan),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_err   (out_err)
  );

  int         checks = 0;
  int         fails  = 0;
  int         stall  = 0;
  logic [7:0] fb [0:15];
  logic [7:0] rb [0:15];
  logic       rl [0:15];
  logic       re [0:15];
  logic [7:0] em [0:NBLK-1][0:7];

  function automatic logic [7:0] pat(int b, int i, int s);
    return 8'(b * 29 + i * 7 + s * 53 + (b >> 3));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic st, input logic [2:0] ch);
    in_valid = 1'b1;
    in_data  = b;
    in_start = st;
    in_chan  = ch;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
  endtask

  task automatic send_frame(input int n, input logic [2:0] ch);
    for (int i = 0; i < n; i++) send_byte(fb[i], (i == 0), ch);
  endtask

  task automatic collect(output int n);
    int  idle;
    bit  done;
    n = 0; idle = 0; done = 0;
    while (idle < 40 && !done) begin
      out_ready = ((stall % 3) != 2);
      stall++;
      if (out_valid && out_ready) begin
        rb[n] = out_data; rl[n] = out_last; re[n] = out_err;
        n++;
        idle = 0;
        if (out_last || n == 16) done = 1;
      end else begin
        idle++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  task automatic do_status(input logic [2:0] ch, output int n);
    fb[0] = 8'd1; fb[1] = 8'd3; fb[2] = 8'h00;
    send_frame(3, ch);
    collect(n);
  endtask

  task automatic do_read(input int off, input logic [2:0] ch, output int n);
    fb[0] = 8'd2; fb[1] = 8'd8; fb[2] = 8'h04; fb[3] = 8'(off);
    send_frame(4, ch);
    collect(n);
  endtask

  task automatic do_write(input int off, input int salt, input logic [2:0] ch, output int n);
    fb[0] = 8'd10; fb[1] = 8'd1; fb[2] = 8'h05; fb[3] = 8'(off);
    for (int i = 0; i < 8; i++) fb[4 + i] = pat(off % NBLK, i, salt);
    send_frame(12, ch);
    collect(n);
  endtask

  task automatic set_model(input int blk, input int salt);
    for (int i = 0; i < 8; i++) em[blk][i] = pat(blk, i, salt);
  endtask

  task automatic check_block(input int off, input int blk, input string tag);
    int n;
    int bad;
    do_read(off, 3'd4, n);
    chk(n == 8, {tag, " beat count"}, n, 8);
    bad = 0;
    for (int i = 0; i < 8; i++) if (rb[i] !== em[blk][i]) bad++;
    chk(bad == 0, {tag, " data"}, {rb[0], rb[1], rb[2], rb[3]},
        {em[blk][0], em[blk][1], em[blk][2], em[blk][3]});
    chk(rl[7] === 1'b1 && rl[6] === 1'b0 && rl[0] === 1'b0, "R10 last only on final beat",
        {rl[0], rl[6], rl[7]}, 3'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: idle after reset
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);

    // R3: status of 4 Kbit part, idle
    do_status(3'd4, n);
    chk(n == 3, "R3 status length", n, 3);
    chk({rb[0], rb[1]} == 16'h8000, "R3 type code", {rb[0], rb[1]}, 16'h8000);
    chk(rb[2] == 8'h00, "R11 not busy after reset", rb[2], 8'h00);
    chk(rl[2] === 1'b1 && rl[1] === 1'b0, "R10 status last", {rl[1], rl[2]}, 2'b01);

    // R5 / R7: write then busy window
    do_write(0, 1, 3'd4, n);
    set_model(0, 1);
    chk(n == 1 && rb[0] == 8'h00 && re[0] == 1'b0, "R5 write ack", rb[0], 8'h00);
    do_status(3'd4, n);
    chk(rb[2] == 8'h80, "R7 busy flag after write", rb[2], 8'h80);
    repeat (BUSYC + 10) @(negedge clk);
    do_status(3'd4, n);
    chk(rb[2] == 8'h00, "R7 busy flag clears", rb[2], 8'h00);

    // R8: read while busy
    do_write(1, 1, 3'd4, n);
    set_model(1, 1);
    do_read(0, 3'd4, n);
    chk(n == 1 && re[0] == 1'b1 && rl[0] == 1'b1, "R8 read refused while busy",
        {n[7:0], 7'd0, re[0]}, {8'd1, 8'd1});
    repeat (BUSYC + 10) @(negedge clk);

    // R8: write while busy leaves the array alone
    do_write(2, 1, 3'd4, n);
    set_model(2, 1);
    do_write(0, 9, 3'd4, n);
    chk(n == 1 && rb[0] == 8'h80, "R8 write refused while busy", rb[0], 8'h80);
    repeat (BUSYC + 10) @(negedge clk);
    check_block(0, 0, "R8 block 0 unchanged");

    // R4 / R5: sweep every block
    for (int b = 0; b < NBLK; b++) begin
      do_write(b, 3, 3'd4, n);
      set_model(b, 3);
      chk(n == 1 && rb[0] == 8'h00, "R5 sweep ack", rb[0], 8'h00);
      repeat (BUSYC + 5) @(negedge clk);
    end
    for (int b = 0; b < NBLK; b++) check_block(b, b, "R4 sweep read");

    // R6: index wrap
    do_write(NBLK + 5, 7, 3'd4, n);
    set_model(5, 7);
    repeat (BUSYC + 5) @(negedge clk);
    check_block(5, 5, "R6 wrapped write");
    check_block(5 + 3 * NBLK, 5, "R6 wrapped read");

    // R2: other channels are silent and harmless
    do_write(10, 11, 3'd1, n);
    chk(n == 0, "R2 write on foreign channel silent", n, 0);
    do_status(3'd0, n);
    chk(n == 0, "R2 status on foreign channel silent", n, 0);
    repeat (BUSYC + 5) @(negedge clk);
    check_block(10, 10, "R2 block 10 unchanged");

    // R9: malformed frames
    fb[0] = 8'd2; fb[1] = 8'd4; fb[2] = 8'h04; fb[3] = 8'd3;
    send_frame(4, 3'd4);
    collect(n);
    chk(n == 1 && re[0] == 1'b1 && rb[0] == 8'h00, "R9 read with wrong receive count",
        {n[7:0], 7'd0, re[0]}, {8'd1, 8'd1});
    fb[0] = 8'd1; fb[1] = 8'd1; fb[2] = 8'h33;
    send_frame(3, 3'd4);
    collect(n);
    chk(n == 1 && re[0] == 1'b1, "R9 unknown opcode", {n[7:0], 7'd0, re[0]}, {8'd1, 8'd1});
    fb[0] = 8'd9; fb[1] = 8'd1; fb[2] = 8'h05; fb[3] = 8'd11;
    for (int i = 0; i < 7; i++) fb[4 + i] = 8'hEE;
    send_frame(11, 3'd4);
    collect(n);
    chk(n == 1 && re[0] == 1'b1, "R9 short write", {n[7:0], 7'd0, re[0]}, {8'd1, 8'd1});
    repeat (BUSYC + 5) @(negedge clk);
    check_block(11, 11, "R9 block 11 unchanged");

    // R1: restart on start byte, stray bytes dropped
    send_byte(8'd1, 1'b1, 3'd4);
    send_byte(8'd3, 1'b0, 3'd4);
    do_status(3'd4, n);
    chk(n == 3 && {rb[0], rb[1], rb[2]} == 24'h800000, "R1 resync after truncated frame",
        {rb[0], rb[1], rb[2]}, 24'h800000);
    send_byte(8'h77, 1'b0, 3'd4);
    do_status(3'd4, n);
    chk(n == 3 && {rb[0], rb[1], rb[2]} == 24'h800000, "R1 stray byte dropped",
        {rb[0], rb[1], rb[2]}, 24'h800000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule